// File: doc/BRIEF.md
# Periodic Tick Interrupt Generator with Lost-Tick Replay

This block produces a periodic interrupt from a 32.768 kHz timebase. The timebase arrives as a single-cycle strobe on the system clock, and a 4-bit rate code selects how many strobes make up one period. An enable bit gates the generator. Each time a period ends, the block raises a periodic flag, an interrupt-request flag and the irq line. At the same cycle it pulses `inject_o` to mark a delivery attempt.

An optional lost-tick mode keeps a count of ticks that the interrupt sink did not take. The sink answers every `inject_o` pulse in the same cycle on `deliver_ok`. Ticks that were not taken are replayed in two ways. The first is on a status acknowledge, up to 20 times between period expiries. The second is a catch-up timer that subdivides the period by the number of ticks still outstanding.

All pins are plain control and status signals. The block has no streaming interface, so it has no back-pressure rules.

Top module: `periodic_tick_irq`

## Requirements
- R1: The period in timebase strobes is 128 for rate code 1, 256 for code 2, and 2^(code-1) for codes 3 to 15. Only cycles with `tbase_stb` high advance the count.
- R2: When the rate code is 0 or `pie_en` is low, the generator stops. No expiry occurs, the phase restarts from zero, and the pending-tick count is cleared.
- R3: An expiry sets `pf_o`, `irqf_o` and `irq_o` from the next cycle on, and pulses `inject_o` in the expiry cycle.
- R4: A `status_ack` cycle without an injection clears `pf_o`, `irqf_o` and `irq_o` in the next cycle.
- R5: In lost-tick mode, an expiry seen with `deliver_ok` low adds one to the pending count, which saturates. With the mode off, the pending count stays zero.
- R6: A `status_ack` replays one tick when all of these hold: the pending count is nonzero, `pie_en` is high, and the acknowledge counter is below 20. A replay pulses `inject_o`, keeps the flags set and adds one to the acknowledge counter. It removes one pending tick if `deliver_ok` is high.
- R7: An expiry in lost-tick mode returns the acknowledge counter to 0 once the counter has reached 20.
- R8: While ticks are pending, the catch-up timer fires every max(1, floor(P/(min(pending,7)+1))) strobes, counted from the last injection. Each catch-up injection with `deliver_ok` high removes one pending tick.
- R9: Only one delivery attempt is made per cycle. An expiry takes that slot, so a coinciding acknowledge neither replays nor counts, and the flags stay set.
- R10: A rate change keeps the strobes already counted. If that count already meets the new period, the expiry occurs on the next strobe.
- R11: Reset clears the flags, the irq line, the pending count and the acknowledge counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbase_stb | input | 1 | One-cycle strobe at the 32.768 kHz timebase rate |
| rate_code | input | 4 | Period select; 0 stops the generator |
| pie_en | input | 1 | Periodic interrupt enable |
| lost_tick_mode | input | 1 | Count and replay undelivered ticks |
| status_ack | input | 1 | Flag acknowledge (status read) strobe |
| deliver_ok | input | 1 | Sink confirms the delivery attempt of this cycle |
| pf_o | output | 1 | Periodic flag |
| irqf_o | output | 1 | Interrupt-request flag |
| irq_o | output | 1 | Interrupt line |
| inject_o | output | 1 | Delivery attempt in this cycle |

## Verification
Two pairs of functions can meet in one cycle. A period expiry can coincide with an acknowledge, and a catch-up firing can also coincide with an acknowledge. The bench provokes the first pair directly: it raises `status_ack` on the exact strobe that ends a period and then expects the flags to stay set. The other coincidences arise in the table runs, where acknowledges at prime spacing and a steady backlog of pending ticks overlap. In every cycle the bench compares `inject_o` and the flags against a model built from the priority order of R9.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
  localparam int RATE_W = 4;

  // which function owns the single delivery slot of a cycle
  typedef enum logic [1:0] {
    SRC_NONE    = 2'd0,
    SRC_TICK    = 2'd1,
    SRC_ACK     = 2'd2,
    SRC_CATCHUP = 2'd3
  } inj_src_e;
endpackage

// File: rtl/tirq_phase.sv
module tirq_phase
  import tirq_pkg::*;
#(
  parameter int PW = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic [PW-1:0]     period,
  output logic              expire
);
  localparam logic [PW-1:0] ONE = {{(PW-1){1'b0}}, 1'b1};

  logic [PW-1:0] phase_q;
  logic [PW:0]   nxt;

  always_comb begin
    period = '0;
    if (rate == 4'd1)      period = PW'(128);
    else if (rate == 4'd2) period = PW'(256);
    else if (rate >= 4'd3) period = ONE << (rate - 4'd1);
  end

  assign nxt    = {1'b0, phase_q} + {{PW{1'b0}}, 1'b1};
  assign expire = run && tick && (nxt >= {1'b0, period});

  always_ff @(posedge clk) begin
    if (!rst_n || !run)  phase_q <= '0;
    else if (tick)       phase_q <= expire ? '0 : nxt[PW-1:0];
  end

  // R1
  exp_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);
  // R2
  stop_no_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !expire);
endmodule

// File: rtl/tirq_catchup.sv
module tirq_catchup #(
  parameter int PW = 15,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          active,
  input  logic          inj_any,
  input  logic [CW-1:0] pend,
  input  logic [PW-1:0] period,
  output logic          due
);
  localparam int XW = PW + 5;

  logic [PW-1:0] cnt_q;
  logic [3:0]    div;
  logic [XW-1:0] kk, lhs;

  assign div = (pend >= CW'(7)) ? 4'd8 : (4'(pend) + 4'd1);
  assign kk  = XW'(cnt_q) + XW'(2);
  assign lhs = kk * XW'(div);
  assign due = active && tick && (lhs > XW'(period));

  always_ff @(posedge clk) begin
    if (!rst_n || !active || inj_any) cnt_q <= '0;
    else if (tick)                    cnt_q <= cnt_q + 1'b1;
  end

  // R8
  cu_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !due);
endmodule

// File: rtl/tirq_pending.sv
module tirq_pending
  import tirq_pkg::*;
#(
  parameter int CW    = 8,
  parameter int LIMIT = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          slew,
  input  logic          pie,
  input  logic          expire,
  input  logic          ack,
  input  logic          cu_due,
  input  logic          delivered,
  output inj_src_e      src,
  output logic [CW-1:0] pend
);
  localparam int AW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] PMAX = '1;

  logic [AW-1:0] acnt_q;
  logic [CW-1:0] pend_q;
  logic          ack_ok;

  assign ack_ok = ack && (pend_q != '0) && pie && (acnt_q < AW'(LIMIT));
  assign pend   = pend_q;

  always_comb begin
    if (expire)      src = SRC_TICK;
    else if (ack_ok) src = SRC_ACK;
    else if (cu_due) src = SRC_CATCHUP;
    else             src = SRC_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run || !slew) pend_q <= '0;
    else begin
      case (src)
        SRC_TICK: if (!delivered && pend_q != PMAX) pend_q <= pend_q + 1'b1;
        SRC_ACK, SRC_CATCHUP: if (delivered) pend_q <= pend_q - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                         acnt_q <= '0;
    else if (src == SRC_ACK)                            acnt_q <= acnt_q + 1'b1;
    else if (expire && slew && acnt_q >= AW'(LIMIT))    acnt_q <= '0;
  end

  // R6
  ack_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acnt_q <= AW'(LIMIT));
  // R5
  pend_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q != '0) |-> ($past(pend_q) == pend_q || $past(pend_q) + 1'b1 == pend_q
                       || $past(pend_q) == pend_q + 1'b1 || !$past(run) || !$past(slew)));
  // R2
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run || !slew) |=> pend_q == '0);
endmodule

// File: rtl/periodic_tick_irq.sv
module periodic_tick_irq
  import tirq_pkg::*;
#(
  parameter int PW        = 15,
  parameter int PENDW     = 8,
  parameter int ACK_LIMIT = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tbase_stb,
  input  logic [3:0] rate_code,
  input  logic       pie_en,
  input  logic       lost_tick_mode,
  input  logic       status_ack,
  input  logic       deliver_ok,
  output logic       pf_o,
  output logic       irqf_o,
  output logic       irq_o,
  output logic       inject_o
);
  logic             run, expire, cu_due, cu_active;
  logic [PW-1:0]    period;
  logic [PENDW-1:0] pend;
  inj_src_e         src;

  assign run       = pie_en && (rate_code != '0);
  assign cu_active = run && lost_tick_mode && (pend != '0);
  assign inject_o  = (src != SRC_NONE);

  tirq_phase #(.PW(PW)) u_phase (
    .clk(clk), .rst_n(rst_n), .tick(tbase_stb), .run(run),
    .rate(rate_code), .period(period), .expire(expire)
  );

  tirq_catchup #(.PW(PW), .CW(PENDW)) u_catchup (
    .clk(clk), .rst_n(rst_n), .tick(tbase_stb), .active(cu_active),
    .inj_any(inject_o), .pend(pend), .period(period), .due(cu_due)
  );

  tirq_pending #(.CW(PENDW), .LIMIT(ACK_LIMIT)) u_pending (
    .clk(clk), .rst_n(rst_n), .run(run), .slew(lost_tick_mode),
    .pie(pie_en), .expire(expire), .ack(status_ack), .cu_due(cu_due),
    .delivered(deliver_ok), .src(src), .pend(pend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_o   <= 1'b0;
      irqf_o <= 1'b0;
      irq_o  <= 1'b0;
    end else if (inject_o) begin
      pf_o   <= 1'b1;
      irqf_o <= 1'b1;
      irq_o  <= 1'b1;
    end else if (status_ack) begin
      pf_o   <= 1'b0;
      irqf_o <= 1'b0;
      irq_o  <= 1'b0;
    end
  end

  // R3
  inj_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inject_o |=> (irq_o && pf_o && irqf_o));
  // R4
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_ack && !inject_o) |=> !irq_o);
  // R9
  exp_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (src == SRC_TICK));
endmodule

// File: tb/periodic_tick_irq_tb_top.sv
module periodic_tick_irq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic r_tick = 1'b1, r_pie = 1'b0, r_slew = 1'b0, r_ack = 1'b0, r_dlv = 1'b1;
  logic [3:0] r_rate = 4'd0;
  logic pf_o, irqf_o, irq_o, inject_o;

  int checks = 0, fails = 0;
  int m_phase, m_pend, m_acnt, m_cu;
  bit m_pf, m_irqf, m_irq, last_inj;

  always #10 clk = ~clk;

  periodic_tick_irq dut_i (
    .clk(clk), .rst_n(rst_n), .tbase_stb(r_tick), .rate_code(r_rate),
    .pie_en(r_pie), .lost_tick_mode(r_slew), .status_ack(r_ack),
    .deliver_ok(r_dlv), .pf_o(pf_o), .irqf_o(irqf_o), .irq_o(irq_o),
    .inject_o(inject_o)
  );

  typedef struct packed {
    logic [3:0]  rate;
    logic        pie;
    logic        slew;
    logic [1:0]  dm;
    logic [7:0]  ackp;
    logic [1:0]  tdiv;
    logic [15:0] n;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{4'd3, 1'b1, 1'b0, 2'd0, 8'd0,  2'd0, 16'd200},
    '{4'd6, 1'b1, 1'b1, 2'd1, 8'd0,  2'd0, 16'd600},
    '{4'd6, 1'b1, 1'b1, 2'd2, 8'd7,  2'd0, 16'd800},
    '{4'd4, 1'b1, 1'b1, 2'd1, 8'd3,  2'd2, 16'd900},
    '{4'd0, 1'b1, 1'b1, 2'd1, 8'd5,  2'd0, 16'd200},
    '{4'd5, 1'b0, 1'b1, 2'd1, 8'd5,  2'd0, 16'd200},
    '{4'd1, 1'b1, 1'b1, 2'd2, 8'd0,  2'd0, 16'd1200},
    '{4'd7, 1'b1, 1'b1, 2'd0, 8'd11, 2'd0, 16'd1500}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R1 R3 vec0";
      1: return "R5 R8 vec1";
      2: return "R6 R9 vec2";
      3: return "R1 R6 vec3";
      4: return "R2 vec4";
      5: return "R2 vec5";
      6: return "R8 vec6";
      default: return "R4 R7 vec7";
    endcase
  endfunction

  function automatic int tb_period(input int r);
    if (r == 0) return 0;
    if (r == 1) return 128;
    if (r == 2) return 256;
    return 2 ** (r - 1);
  endfunction

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s inj/irq/pf/irqf got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic hcheck(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic m_reset();
    m_phase = 0; m_pend = 0; m_acnt = 0; m_cu = 0;
    m_pf = 0; m_irqf = 0; m_irq = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one clock: compare at settle point, then advance the model
  task automatic step(input string tag);
    int p, c, lim, np, na, nph, ncu;
    bit run, ex, ak, cu, inj, act;
    #1;
    run = r_pie && (r_rate != 0);
    p   = tb_period(r_rate);
    ex  = run && r_tick && (m_phase + 1 >= p);
    ak  = r_ack && (m_pend > 0) && r_pie && (m_acnt < 20);
    c   = (m_pend >= 7) ? 8 : m_pend + 1;
    lim = (run && (p / c) > 1) ? p / c : 1;
    act = run && r_slew && (m_pend > 0);
    cu  = act && r_tick && (m_cu + 1 >= lim);
    inj = ex || ak || cu;
    last_inj = inject_o;
    check(tag, {inject_o, irq_o, pf_o, irqf_o}, {inj, m_irq, m_pf, m_irqf});
    np = m_pend;
    if (!run || !r_slew) np = 0;
    else if (ex) begin if (!r_dlv && m_pend < 255) np = m_pend + 1; end
    else if ((ak || cu) && r_dlv) np = m_pend - 1;
    na = m_acnt;
    if (!ex && ak) na = m_acnt + 1;
    else if (ex && r_slew && m_acnt >= 20) na = 0;
    nph = m_phase;
    if (!run) nph = 0;
    else if (r_tick) nph = ex ? 0 : m_phase + 1;
    ncu = m_cu;
    if (!act || inj) ncu = 0;
    else if (r_tick) ncu = m_cu + 1;
    @(posedge clk);
    m_pend = np; m_acnt = na; m_phase = nph; m_cu = ncu;
    if (inj) begin m_pf = 1; m_irqf = 1; m_irq = 1; end
    else if (r_ack) begin m_pf = 0; m_irqf = 0; m_irq = 0; end
    @(negedge clk);
  endtask

  // steps until an injection is seen; returns the step count
  task automatic wait_inj(input string tag, input int maxn, output int n);
    n = 0;
    do begin step(tag); n++; end while (!last_inj && n < maxn);
  endtask

  initial begin
    #(200000 * 20);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n, cnt;
    m_reset();
    repeat (3) @(negedge clk);
    #1;
    // R11 reset state
    hcheck("R11 reset outputs", {pf_o, irqf_o, irq_o, inject_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table-driven runs, model compared every cycle
    for (int i = 0; i < 8; i++) begin
      r_rate = TBL[i].rate; r_pie = TBL[i].pie; r_slew = TBL[i].slew;
      for (int k = 0; k < int'(TBL[i].n); k++) begin
        r_tick = ((k % (int'(TBL[i].tdiv) + 1)) == 0);
        r_ack  = (TBL[i].ackp != 0) && ((k % int'(TBL[i].ackp)) == int'(TBL[i].ackp) - 1);
        r_dlv  = (TBL[i].dm == 0) ? 1'b1 : (TBL[i].dm == 1) ? 1'b0 : 1'(k & 1);
        step(vec_tag(i));
      end
      r_ack = 0; r_tick = 1;
    end

    // R1 period lengths
    r_slew = 0; r_dlv = 1; r_pie = 0; step("R2 stop");
    r_pie = 1; r_rate = 4'd3;
    wait_inj("R1 rate3", 50, n);
    hcheck("R1 rate3 first expiry", n, 4);
    wait_inj("R1 rate3", 50, n);
    hcheck("R1 rate3 interval", n, 4);
    r_rate = 4'd1;
    wait_inj("R1 rate1", 300, n);
    wait_inj("R1 rate1", 300, n);
    hcheck("R1 rate1 interval", n, 128);

    // R2 rate 0 stops everything
    r_rate = 4'd0; cnt = 0;
    for (int k = 0; k < 300; k++) begin step("R2 rate0"); cnt += int'(last_inj); end
    hcheck("R2 no expiry at rate 0", cnt, 0);

    // R10 rate change keeps elapsed count
    r_rate = 4'd8;
    wait_inj("R10", 300, n);
    for (int k = 0; k < 50; k++) step("R10");
    r_rate = 4'd3;
    step("R10 switch");
    hcheck("R10 expiry on first strobe after switch", int'(last_inj), 1);

    // R9 ack on the expiry cycle keeps flags set
    r_pie = 0; step("R9"); r_pie = 1; r_rate = 4'd6;
    for (int k = 0; k < 31; k++) step("R9");
    r_ack = 1; step("R9 coincide"); r_ack = 0;
    hcheck("R9 expiry inject with ack", int'(last_inj), 1);
    step("R9");
    hcheck("R9 irq kept after coinciding ack", int'(irq_o), 1);

    // R6/R7/R11 acknowledge replay limit
    do_reset();
    r_pie = 1; r_rate = 4'd6; r_slew = 1; r_dlv = 0;
    for (int k = 0; k < 960; k++) step("R5 build");
    r_rate = 4'd15; cnt = 0;
    for (int k = 0; k < 25; k++) begin
      r_ack = 1; step("R6 ack"); cnt += int'(last_inj);
      r_ack = 0; step("R6");
    end
    hcheck("R6 replays capped at 20", cnt, 20);
    r_ack = 1; step("R4 ack"); r_ack = 0; step("R4");
    hcheck("R4 irq cleared by plain ack", int'(irq_o), 0);
    r_rate = 4'd6;
    wait_inj("R7", 80, n);
    r_ack = 1; step("R7 ack after expiry"); r_ack = 0;
    hcheck("R7 replay allowed after counter reset", int'(last_inj), 1);

    // R8 catch-up interval with a backlog of 7 or more
    r_rate = 4'd8;
    wait_inj("R8", 300, n);
    wait_inj("R8", 300, n);
    hcheck("R8 catch-up interval 128/8", n, 16);
    r_slew = 0; step("R5 mode off");
    wait_inj("R5", 300, n);
    wait_inj("R5", 300, n);
    hcheck("R5 pending gone when mode off", n, 128);

    // R11 reset clears the backlog
    r_slew = 1; r_dlv = 0;
    for (int k = 0; k < 400; k++) step("R11 build");
    do_reset();
    r_pie = 0; r_ack = 1; step("R11 ack after reset"); r_ack = 0;
    hcheck("R11 no replay after reset", int'(last_inj), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule